// File: doc/BRIEF.md
# Cascadable Bit-Slice ALU with Reconfigurable Look-Ahead Adder

This block is an arithmetic-logic unit built only from identical 4-bit slices. A parameter sets how many slices are chained, so the datapath is any multiple of four bits wide. Every slice receives the same 3-bit operation select and the same exact/approximate mode line. Each slice therefore performs the same operation on its own 4-bit field. Carry ripples from each slice into the one above it.

Inside each slice, eight results are formed side by side: one arithmetic result from a look-ahead adder and seven bitwise results. The select line picks one of them. Subtraction and increment reuse the adder: the operand is inverted or zeroed, and the bottom carry-in is forced to one.

The adder can run in two modes. In exact mode each carry is a full look-ahead over all lower bits of the slice and the incoming carry. In approximate mode each carry inside a slice is formed only from a short window of the nearest lower bit positions, which gives shorter carry logic. The final result and carry-out are registered.

Top module: `slice_alu_chain`

## Requirements
- R1: A synchronous active-high reset clears the registered result and the carry-out to zero.
- R2: The result and carry-out change only at a rising clock edge, and reflect the inputs present just before that edge (one cycle of latency).
- R3: SEL=0 (add), exact mode: {carry-out, result} equals A + B + carry-in.
- R4: SEL=1 (subtract), exact mode: the result is A − B modulo 2^N, and carry-out is 1 exactly when A ≥ B (unsigned). The external carry-in has no effect.
- R5: SEL=7 (increment), exact mode: the result is A + 1 modulo 2^N, and carry-out is 1 exactly when A is all ones. B and the external carry-in have no effect.
- R6: SEL=2 gives A AND B, SEL=3 gives A OR B, SEL=4 gives A XOR B, SEL=5 gives NOT A and SEL=6 gives A unchanged. For all five, the carry-out is 0.
- R7: Approximate mode (mode=1), add, window of 2. Inside each slice, let g = a AND b and p = a XOR b. The carry into local bit k (k=1..4, where k=4 is the slice carry-out) is the OR of g[j] AND p[j+1..k-1] for k−2 ≤ j < k. A slice carry-in term (carry-in AND p[0..k-1]) is included only for k ≤ 2. Each sum bit is p XOR its carry-in. Examples: 0x0007+0x0001 gives 0x0000 with carry 0; 0x00F0+0x0010 gives 0x0080; 0x0003+0x0001 gives 0x0004.
- R8: In exact mode, the carry-out of slice k drives the carry-in of slice k+1, so a carry crosses slice boundaries. For example, 0x000F+0x0001 gives 0x0010, and 0xFFFF+0x0001 gives 0x0000 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Operation select, shared by all slices |
| approx_i | input | 1 | 1 = approximate carry mode, 0 = exact |
| a_i | input | N | Operand A, N = 4 × NUM_SLICES |
| b_i | input | N | Operand B |
| carry_i | input | 1 | Carry into the bottom slice (used by add only) |
| result_o | output | N | Registered ALU result |
| carry_o | output | 1 | Registered carry-out of the top slice |

## Verification
The arithmetic assertions hold only in exact mode, so each one is guarded by the mode value sampled one cycle earlier. Approximate-mode results are checked only by the bench, against hand-computed vectors. All assertions assume that the select, mode, operands and carry-in are driven to known values during and after reset. The bench does this from time zero and changes inputs only on falling edges. The assertions also skip the first cycle after reset, because the register then shows the reset value and not a computed result.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD   = 3'd0,
      OP_SUB   = 3'd1,
      OP_AND   = 3'd2,
      OP_OR    = 3'd3,
      OP_XOR   = 3'd4,
      OP_NOTA  = 3'd5,
      OP_PASSA = 3'd6,
      OP_INCA  = 3'd7
   } alu_op_e;

   localparam int OP_COUNT = 8;

   function automatic logic op_is_arith(input alu_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INCA);
   endfunction

endpackage

// File: rtl/slice_rcla.sv
module slice_rcla #(
   parameter int W   = 4,
   parameter int WIN = 2
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   input  logic         approx_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);

   logic [W-1:0] gen;
   logic [W-1:0] prop;
   logic [W:0]   c_exact;
   logic [W:0]   c_apx;
   logic [W:0]   c_use;

   assign gen  = a_i & b_i;
   assign prop = a_i ^ b_i;

   // carry into position k from generate bits lo..k-1, plus cin when lo==0
   function automatic logic la_carry(input logic [W-1:0] g,
                                     input logic [W-1:0] p,
                                     input logic         ci,
                                     input int           k,
                                     input int           lo);
      logic acc;
      logic run;
      acc = 1'b0;
      for (int j = 0; j < W; j++) begin
         if (j >= lo && j < k) begin
            run = g[j];
            for (int m = 0; m < W; m++) begin
               if (m > j && m < k) run = run & p[m];
            end
            acc = acc | run;
         end
      end
      if (lo == 0) begin
         run = ci;
         for (int m = 0; m < W; m++) begin
            if (m < k) run = run & p[m];
         end
         acc = acc | run;
      end
      return acc;
   endfunction

   assign c_exact[0] = cin_i;
   assign c_apx[0]   = cin_i;

   for (genvar k = 1; k <= W; k++) begin : g_carry
      assign c_exact[k] = la_carry(gen, prop, cin_i, k, 0);
      if (WIN >= W) begin : g_full
         assign c_apx[k] = c_exact[k];
      end else begin : g_window
         localparam int LO = (k > WIN) ? (k - WIN) : 0;
         assign c_apx[k] = la_carry(gen, prop, cin_i, k, LO);
      end
   end

   assign c_use  = approx_i ? c_apx : c_exact;
   assign sum_o  = prop ^ c_use[W-1:0];
   assign cout_o = c_use[W];

endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import slice_alu_pkg::*;
#(
   parameter int W   = 4,
   parameter int WIN = 2
) (
   input  alu_op_e      op_i,
   input  logic         approx_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] y_o,
   output logic         cout_o
);

   logic [W-1:0] b_cond;
   logic [W-1:0] sum;
   logic [W-1:0] res [OP_COUNT];

   always_comb begin
      unique case (op_i)
         OP_SUB:  b_cond = ~b_i;
         OP_INCA: b_cond = '0;
         default: b_cond = b_i;
      endcase
   end

   slice_rcla #(.W(W), .WIN(WIN)) u_add (
      .a_i      (a_i),
      .b_i      (b_cond),
      .cin_i    (cin_i),
      .approx_i (approx_i),
      .sum_o    (sum),
      .cout_o   (cout_o)
   );

   // all eight results formed in parallel
   assign res[OP_ADD]   = sum;
   assign res[OP_SUB]   = sum;
   assign res[OP_AND]   = a_i & b_i;
   assign res[OP_OR]    = a_i | b_i;
   assign res[OP_XOR]   = a_i ^ b_i;
   assign res[OP_NOTA]  = ~a_i;
   assign res[OP_PASSA] = a_i;
   assign res[OP_INCA]  = sum;

   assign y_o = res[op_i];

endmodule

// File: rtl/slice_alu_chain.sv
module slice_alu_chain
   import slice_alu_pkg::*;
#(
   parameter int NUM_SLICES = 4,
   parameter int SLICE_W    = 4,
   parameter int APX_WIN    = 2,
   localparam int N         = NUM_SLICES * SLICE_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [2:0]   sel_i,
   input  logic         approx_i,
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   input  logic         carry_i,
   output logic [N-1:0] result_o,
   output logic         carry_o
);

   if (NUM_SLICES < 1) begin : g_bad_count
      $error("NUM_SLICES must be at least 1");
   end
   if (SLICE_W != 4) begin : g_bad_width
      $error("SLICE_W must be 4");
   end
   if (APX_WIN < 1) begin : g_bad_win
      $error("APX_WIN must be at least 1");
   end

   alu_op_e          op;
   logic [NUM_SLICES:0] chain;
   logic [N-1:0]     y_comb;
   logic             is_arith;

   assign op       = alu_op_e'(sel_i);
   assign is_arith = op_is_arith(op);

   always_comb begin
      unique case (op)
         OP_ADD:          chain[0] = carry_i;
         OP_SUB, OP_INCA: chain[0] = 1'b1;
         default:         chain[0] = 1'b0;
      endcase
   end

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      alu_slice #(.W(SLICE_W), .WIN(APX_WIN)) u_slice (
         .op_i     (op),
         .approx_i (approx_i),
         .a_i      (a_i[s*SLICE_W +: SLICE_W]),
         .b_i      (b_i[s*SLICE_W +: SLICE_W]),
         .cin_i    (chain[s]),
         .y_o      (y_comb[s*SLICE_W +: SLICE_W]),
         .cout_o   (chain[s+1])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         result_o <= '0;
         carry_o  <= 1'b0;
      end else begin
         result_o <= y_comb;
         carry_o  <= is_arith ? chain[NUM_SLICES] : 1'b0;
      end
   end

endmodule

module slice_alu_chain_chk #(
   parameter int N = 16
) (
   input logic         clk,
   input logic         rst,
   input logic [2:0]   sel_i,
   input logic         approx_i,
   input logic [N-1:0] a_i,
   input logic [N-1:0] b_i,
   input logic         carry_i,
   input logic [N-1:0] result_o,
   input logic         carry_o
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (result_o == '0 && carry_o == 1'b0));

   // R3
   add_exact_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(sel_i) == 3'd0 && !$past(approx_i)) |->
      ({carry_o, result_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}
                               + {{N{1'b0}}, $past(carry_i)})));

   // R4
   sub_exact_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(sel_i) == 3'd1 && !$past(approx_i)) |->
      (result_o == N'($past(a_i) - $past(b_i)) &&
       carry_o == ($past(a_i) >= $past(b_i))));

   // R5
   inc_exact_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(sel_i) == 3'd7 && !$past(approx_i)) |->
      (result_o == N'($past(a_i) + 1'b1) && carry_o == (&$past(a_i))));

   // R6
   logic_carry_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(sel_i) inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd6}) |->
      (carry_o == 1'b0));

   // R6
   xor_result_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(sel_i) == 3'd4) |->
      (result_o == ($past(a_i) ^ $past(b_i))));

   // R2
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $stable(sel_i) && $stable(approx_i) && $stable(a_i)
       && $stable(b_i) && $stable(carry_i)) |=> $stable(result_o));

endmodule

bind slice_alu_chain slice_alu_chain_chk #(.N(N)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .sel_i    (sel_i),
   .approx_i (approx_i),
   .a_i      (a_i),
   .b_i      (b_i),
   .carry_i  (carry_i),
   .result_o (result_o),
   .carry_o  (carry_o)
);

// File: tb/slice_alu_chain_tb.sv
`timescale 1ns/1ps
module slice_alu_chain_tb;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [2:0]   sel = 3'd0;
   logic         apx = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic         cin = 1'b0;
   logic [W-1:0] res;
   logic         cout;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   slice_alu_chain #(.NUM_SLICES(4)) u_dut (
      .clk(clk), .rst(rst), .sel_i(sel), .approx_i(apx),
      .a_i(a), .b_i(b), .carry_i(cin), .result_o(res), .carry_o(cout)
   );

   task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got carry=%0b res=%h, expected carry=%0b res=%h",
                  req, got[W], got[W-1:0], exp[W], exp[W-1:0]);
      end
   endtask

   task automatic drive(input logic [2:0] s, input logic m, input logic [W-1:0] va,
                        input logic [W-1:0] vb, input logic c);
      @(negedge clk);
      sel = s; apx = m; a = va; b = vb; cin = c;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [W:0] model(input logic [2:0] s, input logic [W-1:0] va,
                                        input logic [W-1:0] vb, input logic c);
      case (s)
         3'd0: return {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, c};
         3'd1: return {(va >= vb), W'(va - vb)};
         3'd2: return {1'b0, va & vb};
         3'd3: return {1'b0, va | vb};
         3'd4: return {1'b0, va ^ vb};
         3'd5: return {1'b0, ~va};
         3'd6: return {1'b0, va};
         default: return {1'b0, va} + 17'd1;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] s);
      case (s)
         3'd0: return "R3 add";
         3'd1: return "R4 sub";
         3'd7: return "R5 inc";
         default: return "R6 logic";
      endcase
   endfunction

   task automatic t_reset();
      rst = 1'b1;
      sel = 3'd0; a = 16'hFFFF; b = 16'h0001; cin = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check("R1 reset", {cout, res}, 17'h0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_latency();
      drive(3'd0, 1'b0, 16'h0010, 16'h0001, 1'b0);
      check("R2 first", {cout, res}, 17'h00011);
      @(negedge clk);
      a = 16'h0100;
      #1;
      check("R2 before edge", {cout, res}, 17'h00011);
      @(posedge clk);
      #1;
      check("R2 after edge", {cout, res}, 17'h00101);
   endtask

   task automatic t_carry_chain();
      drive(3'd0, 1'b0, 16'h000F, 16'h0001, 1'b0);
      check("R8 slice0->1", {cout, res}, 17'h00010);
      drive(3'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b0);
      check("R8 full ripple", {cout, res}, 17'h10000);
      drive(3'd0, 1'b0, 16'h0FFF, 16'h0000, 1'b1);
      check("R3 carry-in", {cout, res}, 17'h01000);
   endtask

   task automatic t_sub_inc();
      drive(3'd1, 1'b0, 16'h0005, 16'h0003, 1'b0);
      check("R4 sub no borrow, cin ignored", {cout, res}, 17'h10002);
      drive(3'd1, 1'b0, 16'h0003, 16'h0005, 1'b1);
      check("R4 sub borrow", {cout, res}, 17'h0FFFE);
      drive(3'd7, 1'b0, 16'h00FF, 16'hFFFF, 1'b1);
      check("R5 inc, B and cin ignored", {cout, res}, 17'h00100);
      drive(3'd7, 1'b0, 16'hFFFF, 16'h1234, 1'b0);
      check("R5 inc wrap", {cout, res}, 17'h10000);
   endtask

   task automatic t_logic();
      drive(3'd2, 1'b0, 16'hF0F0, 16'hFF00, 1'b1);
      check("R6 and", {cout, res}, 17'h0F000);
      drive(3'd3, 1'b0, 16'hF0F0, 16'h0F00, 1'b1);
      check("R6 or", {cout, res}, 17'h0FFF0);
      drive(3'd4, 1'b0, 16'hAAAA, 16'hFFFF, 1'b1);
      check("R6 xor", {cout, res}, 17'h05555);
      drive(3'd5, 1'b0, 16'h1234, 16'hFFFF, 1'b1);
      check("R6 not", {cout, res}, 17'h0EDCB);
      drive(3'd6, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1);
      check("R6 pass", {cout, res}, 17'h0FFFF);
   endtask

   task automatic t_sweep();
      logic [W-1:0] x = 16'hACE1;
      logic [W-1:0] y = 16'h5A3C;
      for (int i = 0; i < 48; i++) begin
         x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
         y = {y[14:0], y[15] ^ y[13] ^ y[12] ^ y[10]};
         drive(3'(i % 8), 1'b0, x, y, x[0]);
         check(req_of(3'(i % 8)), {cout, res}, model(3'(i % 8), x, y, x[0]));
      end
   endtask

   task automatic t_approx();
      drive(3'd0, 1'b1, 16'h0007, 16'h0001, 1'b0);
      check("R7 lost carry", {cout, res}, 17'h00000);
      drive(3'd0, 1'b1, 16'h00F0, 16'h0010, 1'b0);
      check("R7 lost carry slice1", {cout, res}, 17'h00080);
      drive(3'd0, 1'b1, 16'h0003, 16'h0001, 1'b0);
      check("R7 short chain exact", {cout, res}, 17'h00004);
      drive(3'd0, 1'b1, 16'h1234, 16'h4321, 1'b0);
      check("R7 no carries", {cout, res}, 17'h05555);
   endtask

   initial begin
      t_reset();
      t_latency();
      t_carry_chain();
      t_sub_inc();
      t_logic();
      t_approx();
      t_sweep();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule